// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block supervises a processor by watching a single software-driven input, the service line. Every change of level on that line, whether rising or falling, restarts an internal cycle counter. If the line stays at one level for a full timeout window, the block raises a one-cycle expiry request. A separate reset generator turns that request into a system reset. While that system reset is active, the counter is kept at zero. Counting starts again on the first clock after the reset goes away.

The service line is asynchronous to the block clock, so it is brought through a synchronizer before edges are detected. A second input tells the block that the service line is floating. In that case an internal pattern is used in place of the line. The pattern is low for seven eighths of its period and high for the last eighth. Its period is shorter than the timeout, so the pattern keeps the counter from ever expiring, and this is how the watchdog is switched off. The timeout and the pattern period are both parameters given in clock cycles.

Top module: `wdog_edge_monitor`

## Requirements
- R1: While the synchronous block reset `rst` is high, `expire_req` is 0 and the counter is cleared.
- R2: While `sys_rst_active` is high, the counter stays at zero and `expire_req` stays 0. With a steady service line, the first `expire_req` pulse comes exactly TIMEOUT_CYC clock edges after `sys_rst_active` falls.
- R3: A rising change on `wd_in` restarts the count. With no further change, `expire_req` goes high exactly TIMEOUT_CYC+3 clock edges after the change: two synchronizer stages, one edge-compare register, then the full window.
- R4: A falling change on `wd_in` restarts the count in the same way and with the same TIMEOUT_CYC+3 latency.
- R5: `expire_req` is high for exactly one cycle. The counter then restarts on its own, so a steady line produces a pulse every TIMEOUT_CYC cycles.
- R6: A pulse on `wd_in` held for two clock cycles is seen as two valid changes. The later change sets the TIMEOUT_CYC+3 latency.
- R7: While `wd_float` is 1, `wd_in` is replaced by an internal pattern of period SVC_PERIOD_CYC. The pattern is high for SVC_PERIOD_CYC/8 cycles and low for the rest. It never lets the counter expire. Once `wd_float` returns to 0 with a steady line, expiry resumes within TIMEOUT_CYC+4 cycles.
- R8: A line that toggles at intervals shorter than the timeout never causes an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_active | input | 1 | High while the system reset is asserted; holds the counter at zero |
| wd_in | input | 1 | Asynchronous service line toggled by software |
| wd_float | input | 1 | High when the service line is floating; selects the internal pattern |
| expire_req | output | 1 | Registered one-cycle request to the reset generator |

## Verification
The service line is driven with a single rising step and with a single falling step. It is also driven with a two-cycle pulse, a steady level, and a regular toggle faster than the window. Measuring the exact number of cycles to expiry after each change tells whether both polarities clear the counter, whether the pipeline latency is right, and whether short pulses are lost. A steady line shows the pulse is one cycle wide and repeats with the right period. Holding the line steady while the float flag is set shows that the internal pattern, and only that pattern, keeps the timer serviced: expiry returns once the flag drops.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_svc_gen.sv
module wdog_svc_gen #(
  parameter int PERIOD_CYC = 48
) (
  input  logic clk,
  input  logic rst,
  output logic level
);
  localparam int HIGH_CYC = (PERIOD_CYC / 8 < 1) ? 1 : PERIOD_CYC / 8;
  localparam int LOW_CYC  = PERIOD_CYC - HIGH_CYC;
  localparam int PW       = wdog_pkg::cnt_width(PERIOD_CYC);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_CYC - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(LOW_CYC);

  logic [PW-1:0] phase_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      level_q <= 1'b0;
    end else begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      level_q <= (phase_q >= PH_HIGH);
    end
  end

  assign level = level_q;
endmodule

// File: rtl/wdog_edge_det.sv
module wdog_edge_det (
  input  logic           clk,
  input  logic           rst,
  input  logic           s,
  output wdog_pkg::edge_t edg
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= s;
  end

  assign edg.rise = s & ~prev_q;
  assign edg.fall = ~s & prev_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TIMEOUT_CYC = 64,
  parameter int CW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          service,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] count_q;
  logic          expire_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (service) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (count_q == LAST) begin
      count_q  <= '0;
      expire_q <= 1'b1;
    end else begin
      count_q  <= count_q + 1'b1;
      expire_q <= 1'b0;
    end
  end

  assign count  = count_q;
  assign expire = expire_q;
endmodule

// File: rtl/wdog_edge_monitor.sv
module wdog_edge_monitor #(
  parameter int TIMEOUT_CYC   = 64,
  parameter int SVC_PERIOD_CYC = 48,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_rst_active,
  input  logic wd_in,
  input  logic wd_float,
  output logic expire_req
);
  localparam int CNT_W = wdog_pkg::cnt_width(TIMEOUT_CYC);

  logic            svc_level;
  logic            line_sel;
  logic            line_sync;
  wdog_pkg::edge_t edg;
  logic            edge_any;
  logic [CNT_W-1:0] cnt_q;

  wdog_svc_gen #(.PERIOD_CYC(SVC_PERIOD_CYC)) u_svc (
    .clk(clk), .rst(rst), .level(svc_level)
  );

  assign line_sel = wd_float ? svc_level : wd_in;

  wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_sel), .q(line_sync)
  );

  wdog_edge_det u_edge (
    .clk(clk), .rst(rst), .s(line_sync), .edg(edg)
  );

  assign edge_any = edg.rise | edg.fall;

  wdog_counter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(sys_rst_active), .service(edge_any),
    .count(cnt_q), .expire(expire_req)
  );
endmodule

// File: rtl/wdog_edge_monitor_chk.sv
module wdog_edge_monitor_chk #(
  parameter int TIMEOUT_CYC = 64,
  parameter int CW          = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          sys_rst_active,
  input logic          expire_req,
  input logic          any_edge,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !expire_req));

  a_r2_hold_in_sysrst: assert property (@(posedge clk) disable iff (rst)
    sys_rst_active |=> (cnt == '0 && !expire_req));

  // R3 and R4: either polarity restarts the count
  a_r3_edge_restarts: assert property (@(posedge clk) disable iff (rst)
    any_edge |=> cnt == '0);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    expire_req |=> !expire_req);

  a_r5_expire_at_window_end: assert property (@(posedge clk) disable iff (rst)
    $rose(expire_req) |-> $past(cnt) == LAST);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

bind wdog_edge_monitor wdog_edge_monitor_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .CW(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .sys_rst_active(sys_rst_active),
  .expire_req(expire_req), .any_edge(edge_any), .cnt(cnt_q)
);

// File: tb/sim_wdog_edge_monitor.sv
`timescale 1ns/1ps
module sim_wdog_edge_monitor;
  localparam int T = 64;
  localparam int P = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_rst = 1'b1;
  logic wd_in = 1'b0;
  logic wd_float = 1'b0;
  logic expire;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  wdog_edge_monitor #(.TIMEOUT_CYC(T), .SVC_PERIOD_CYC(P), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sys_rst_active(sys_rst),
    .wd_in(wd_in), .wd_float(wd_float), .expire_req(expire)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // steps until expire is seen, 0 if not within lim
  task automatic steps_to_expire(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (expire) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic hold_release();
    sys_rst = 1'b1;
    repeat (5) step();
    sys_rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    sys_rst = 1'b1;
    repeat (4) step();
    chk(expire == 1'b0, "R1 expire low in reset", int'(expire), 0);
    rst = 1'b0;
    step();
    chk(expire == 1'b0, "R1 expire low after reset", int'(expire), 0);
  endtask

  task automatic t_release();
    int n;
    int hi;
    sys_rst = 1'b1;
    hi = 0;
    for (int i = 0; i < 2 * T; i++) begin
      step();
      if (i == 4) wd_in = ~wd_in;
      if (expire) hi++;
    end
    wd_in = 1'b0;
    repeat (5) step();
    chk(hi == 0, "R2 no expiry while system reset held", hi, 0);
    sys_rst = 1'b0;
    steps_to_expire(4 * T, n);
    chk(n == T, "R2 cycles from release to expiry", n, T);
  endtask

  task automatic t_rise();
    int n;
    wd_in = 1'b0;
    hold_release();
    repeat (10) step();
    wd_in = 1'b1;
    steps_to_expire(4 * T, n);
    chk(n == T + 3, "R3 cycles from rising change to expiry", n, T + 3);
  endtask

  task automatic t_fall();
    int n;
    wd_in = 1'b1;
    hold_release();
    repeat (10) step();
    wd_in = 1'b0;
    steps_to_expire(4 * T, n);
    chk(n == T + 3, "R4 cycles from falling change to expiry", n, T + 3);
  endtask

  task automatic t_repeat();
    int hi;
    int adj;
    int third;
    bit prev;
    wd_in = 1'b0;
    hold_release();
    hi = 0; adj = 0; third = 0; prev = 1'b0;
    for (int i = 1; i <= 3 * T; i++) begin
      step();
      if (expire) begin
        hi++;
        if (prev) adj++;
        if (hi == 3) third = i;
      end
      prev = expire;
    end
    chk(hi == 3, "R5 pulses in three windows", hi, 3);
    chk(adj == 0, "R5 pulse width one cycle", adj, 0);
    chk(third == 3 * T, "R5 third pulse position", third, 3 * T);
  endtask

  task automatic t_short();
    int n;
    wd_in = 1'b0;
    hold_release();
    repeat (5) step();
    wd_in = 1'b1;
    repeat (2) step();
    wd_in = 1'b0;
    steps_to_expire(4 * T, n);
    chk(n == T + 3, "R6 two-cycle pulse restarts count", n, T + 3);
  endtask

  task automatic t_float();
    int hi;
    int n;
    wd_in = 1'b0;
    wd_float = 1'b1;
    hold_release();
    hi = 0;
    for (int i = 0; i < 6 * T; i++) begin
      step();
      if (expire) hi++;
    end
    chk(hi == 0, "R7 floating line never expires", hi, 0);
    wd_float = 1'b0;
    steps_to_expire(T + 4, n);
    chk(n != 0, "R7 expiry returns after float cleared", n, T + 4);
  endtask

  task automatic t_toggle();
    int hi;
    wd_in = 1'b0;
    hold_release();
    hi = 0;
    for (int i = 1; i <= 8 * T; i++) begin
      step();
      if (expire) hi++;
      if (i % (T / 2) == 0) wd_in = ~wd_in;
    end
    chk(hi == 0, "R8 regular toggling never expires", hi, 0);
  endtask

  initial begin
    t_reset();
    t_release();
    t_rise();
    t_fall();
    t_repeat();
    t_short();
    t_float();
    t_toggle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule